// File: doc/BRIEF.md
# Address Breakpoint and Single-Step Controller

This block sits beside a bus and watches every cycle the bus master runs. Three inputs come from the operator's switches: a 24-bit breakpoint value, a breakpoint enable and a stop control. A fourth is a step push-button. The block holds the bus-ready line low, which freezes whichever processor currently owns the bus, in two cases:

- A strobed bus address equals the switch value while the enable is on.
- The stop control is on.

The block only looks at bus cycles, so it does not care which kind of processor is the master or where in the 24-bit space the address lies.

While the master is frozen, each press of the step button releases the ready hold. The master then finishes the stalled cycle and runs until the next sync strobe, where the hold is applied again. The operator can therefore walk forward one bus cycle per press. Turning both the stop and the breakpoint enable off lets the master run on from where it stopped.

All three operator controls pass through a synchronizer and a debounce counter before they are used. The step button is also edge-detected, so one press gives one release however long it is held. A reset clears the held state.

Top module: `bp_step_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rdy_hold_n is 1.
- R2: With the debounced enable on, a cycle with addr_valid=1 and bus_addr equal to bp_addr_sw drives rdy_hold_n to 0 on the second rising edge after that cycle is sampled, and it stays 0.
- R3: A matching bus_addr presented with addr_valid=0 never produces a hold.
- R4: A matching, strobed address while the debounced enable is off never produces a hold.
- R5: Setting stop_sw to 1 drives rdy_hold_n to 0 within DEB_CYCLES+4 cycles, whatever the bus address.
- R6: While held, a debounced rising edge of step_sw sets rdy_hold_n to 1. It stays 1 until a cycle with bus_sync=1, and it is 0 from the edge that samples that sync.
- R7: Keeping step_sw pressed gives no second release. A new release needs step_sw to go back to 0 and then to 1.
- R8: While held, turning both stop_sw and bp_en_sw off returns rdy_hold_n to 1 within DEB_CYCLES+4 cycles.
- R9: A switch level that lasts fewer than DEB_CYCLES cycles has no effect on rdy_hold_n.
- R10: Asserting reset while held returns rdy_hold_n to 1 at once.
- R11: An address that differs from bp_addr_sw in any single bit does not produce a hold, even with addr_valid=1 and the enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Address currently on the bus |
| addr_valid | input | 1 | High when bus_addr is stable and valid |
| bus_sync | input | 1 | High in the first cycle of each bus cycle |
| bp_addr_sw | input | 24 | Breakpoint address from the switches |
| bp_en_sw | input | 1 | Breakpoint enable switch (raw) |
| stop_sw | input | 1 | Stop switch (raw) |
| step_sw | input | 1 | Step push-button (raw) |
| rdy_hold_n | output | 1 | Active-low bus-ready hold |

## Verification
The random sweep presents addresses one bit away from the breakpoint, in every bit lane. A comparator that drops a bit or a lane would freeze the bus there.

Directed cases cover four mistakes:

- **Unqualified comparison:** a match with the strobe low would stall the master on a glitch.
- **Level-sensitive step:** holding the step button would release again and again, so the master would run on instead of stopping after one cycle.
- **Short bounce:** a 3-cycle bounce would take a step when none was pressed.
- **Missing resume path:** clearing the stop and enable switches would leave the bus frozen for good.

// File: rtl/bp_step_pkg.sv
package bp_step_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_STEP = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/bp_debounce.sv
// Two-stage synchronizer followed by a stability counter; emits a one-cycle
// pulse when the filtered level rises.
module bp_debounce #(
    parameter int DEB_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          level;
        logic [CW-1:0] cnt;
        logic          rise;
    } deb_t;

    deb_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        d.rise = 1'b0;
        if (q.sync[1] != q.level) begin
            if (q.cnt == CW'(DEB_CYCLES - 1)) begin
                d.level = q.sync[1];
                d.cnt   = '0;
                d.rise  = q.sync[1];
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.level;
    assign rise_o  = q.rise;

    // R7: the edge pulse never lasts more than one cycle
    a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        q.rise |=> !q.rise);
    // R9: the filtered level only rises together with its pulse
    a_r9_rise_with_level: assert property (@(posedge clk) disable iff (!rst_n)
        q.rise |-> q.level);
endmodule

// File: rtl/bp_addr_match.sv
// Registered, strobe-qualified address comparator built from byte lanes.
module bp_addr_match #(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] ref_i,
    input  logic              strobe_i,
    input  logic              en_i,
    output logic              hit_o
);
    localparam int LANES = (ADDR_W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    typedef struct packed {
        logic hit;
    } match_t;

    match_t q, d;

    logic [PAD_W-1:0] a_pad;
    logic [PAD_W-1:0] r_pad;
    logic [LANES-1:0] lane_eq;

    assign a_pad = PAD_W'(addr_i);
    assign r_pad = PAD_W'(ref_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (a_pad[g*LANE_W +: LANE_W] == r_pad[g*LANE_W +: LANE_W]);
    end

    always_comb begin
        d     = q;
        d.hit = strobe_i && en_i && (&lane_eq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hit_o = q.hit;

    // R3: no valid strobe, no hit
    a_r3_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !hit_o);
    // R4: no enable, no hit
    a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !hit_o);
endmodule

// File: rtl/bp_step_ctl.sv
// Run / hold / step sequencer that drives the ready hold.
module bp_step_ctl
    import bp_step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic stop_i,
    input  logic bp_en_i,
    input  logic step_rise_i,
    input  logic sync_i,
    output logic hold_o
);
    typedef struct packed {
        ctl_state_e state;
    } ctl_t;

    ctl_t q, d;
    logic halt_req;

    assign halt_req = stop_i || bp_en_i;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_RUN: begin
                if (stop_i || hit_i) d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (step_rise_i)    d.state = ST_STEP;
                else if (!halt_req) d.state = ST_RUN;
            end
            ST_STEP: begin
                if (!halt_req)   d.state = ST_RUN;
                else if (sync_i) d.state = ST_HOLD;
            end
            default: d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_RUN;
        end else begin
            q <= d;
        end
    end

    assign hold_o = (q.state == ST_HOLD);

    // R2: a registered hit while running freezes the master
    a_r2_hit_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && hit_i) |=> hold_o);
    // R5: stop while running freezes the master
    a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN && stop_i) |=> hold_o);
    // R6: a step edge while held releases the hold
    a_r6_step_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && step_rise_i) |=> !hold_o);
    // R6: the next sync while stepping re-applies the hold
    a_r6_sync_reholds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STEP && sync_i && halt_req) |=> hold_o);
    // R8: clearing both controls lets the master run
    a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !halt_req && !step_rise_i) |=> (q.state == ST_RUN));
endmodule

// File: rtl/bp_step_top.sv
module bp_step_top
    import bp_step_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DEB_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              addr_valid,
    input  logic              bus_sync,
    input  logic [ADDR_W-1:0] bp_addr_sw,
    input  logic              bp_en_sw,
    input  logic              stop_sw,
    input  logic              step_sw,
    output logic              rdy_hold_n
);
    localparam int NSW     = 3;
    localparam int SW_EN   = 0;
    localparam int SW_STOP = 1;
    localparam int SW_STEP = 2;

    logic [NSW-1:0] sw_raw;
    logic [NSW-1:0] sw_level;
    logic [NSW-1:0] sw_rise;
    logic           hit;
    logic           hold;

    assign sw_raw = {step_sw, stop_sw, bp_en_sw};

    for (genvar s = 0; s < NSW; s++) begin : g_deb
        bp_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (sw_raw[s]),
            .level_o (sw_level[s]),
            .rise_o  (sw_rise[s])
        );
    end

    bp_addr_match #(.ADDR_W(ADDR_W)) i_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .ref_i    (bp_addr_sw),
        .strobe_i (addr_valid),
        .en_i     (sw_level[SW_EN]),
        .hit_o    (hit)
    );

    bp_step_ctl i_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .stop_i      (sw_level[SW_STOP]),
        .bp_en_i     (sw_level[SW_EN]),
        .step_rise_i (sw_rise[SW_STEP]),
        .sync_i      (bus_sync),
        .hold_o      (hold)
    );

    assign rdy_hold_n = ~hold;

    // R1 / R10: reset always leaves the bus free to run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r10_reset_releases: assert (rdy_hold_n);
        end
    end
endmodule

// File: tb/test_bp_step_top.sv
module test_bp_step_top;
    localparam int AW  = 24;
    localparam int DEB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          addr_valid = 1'b0;
    logic          bus_sync = 1'b0;
    logic [AW-1:0] bp_addr_sw = '0;
    logic          bp_en_sw = 1'b0;
    logic          stop_sw = 1'b0;
    logic          step_sw = 1'b0;
    logic          rdy_hold_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bp_step_top #(.ADDR_W(AW), .DEB_CYCLES(DEB)) i_bp_step_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .addr_valid (addr_valid),
        .bus_sync   (bus_sync),
        .bp_addr_sw (bp_addr_sw),
        .bp_en_sw   (bp_en_sw),
        .stop_sw    (stop_sw),
        .step_sw    (step_sw),
        .rdy_hold_n (rdy_hold_n)
    );

    function automatic logic exp_hit(input logic [AW-1:0] a, input logic [AW-1:0] r,
                                     input logic en, input logic strobe);
        return en && strobe && (a == r);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic settle();
        cyc(DEB + 5);
    endtask

    task automatic sync_pulse();
        bus_sync = 1'b1;
        cyc(1);
        bus_sync = 1'b0;
    endtask

    initial begin
        logic [AW-1:0] a;
        logic          en_model;
        int            took;
        void'($urandom(32'd4711));
        bp_addr_sw = AW'($urandom);

        // R1: reset state
        cyc(3);
        chk(rdy_hold_n, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        cyc(1);
        chk(rdy_hold_n, 1'b1, "R1 after reset");

        // R4: match with enable off
        bus_addr = bp_addr_sw; addr_valid = 1'b1;
        cyc(1);
        addr_valid = 1'b0;
        cyc(3);
        chk(rdy_hold_n, ~exp_hit(bus_addr, bp_addr_sw, 1'b0, 1'b1), "R4 enable off");

        // R3: match without strobe
        bp_en_sw = 1'b1;
        settle();
        bus_addr = bp_addr_sw; addr_valid = 1'b0;
        cyc(4);
        chk(rdy_hold_n, 1'b1, "R3 no strobe");

        // R11: random near-miss sweep
        en_model = 1'b1;
        for (int i = 0; i < 300; i++) begin
            a = bp_addr_sw ^ (AW'(1) << ($urandom % AW));
            if (i % 3 == 0) a = AW'($urandom) | AW'(1);
            if (a == bp_addr_sw) a = ~a;
            bus_addr   = a;
            addr_valid = 1'($urandom);
            cyc(1);
            chk(rdy_hold_n, ~exp_hit(a, bp_addr_sw, en_model, addr_valid), "R11 near miss");
        end
        addr_valid = 1'b0;
        cyc(2);
        chk(rdy_hold_n, 1'b1, "R11 after sweep");

        // R2: exact hit halts on the second edge
        bus_addr = bp_addr_sw; addr_valid = 1'b1;
        cyc(1);
        addr_valid = 1'b0; bus_addr = ~bp_addr_sw;
        chk(rdy_hold_n, 1'b1, "R2 one edge after hit");
        cyc(1);
        chk(rdy_hold_n, 1'b0, "R2 hold applied");
        cyc(10);
        chk(rdy_hold_n, 1'b0, "R2 hold kept");

        // R6: step press releases until sync
        step_sw = 1'b1;
        took = 0;
        while (rdy_hold_n !== 1'b1 && took < 4 * DEB) begin
            cyc(1);
            took++;
        end
        chk(rdy_hold_n, 1'b1, "R6 step release");
        cyc(15);
        chk(rdy_hold_n, 1'b1, "R6 released until sync");
        sync_pulse();
        chk(rdy_hold_n, 1'b0, "R6 rehold at sync");

        // R7: held button gives no second release
        cyc(30);
        chk(rdy_hold_n, 1'b0, "R7 held button");
        step_sw = 1'b0;
        settle();
        chk(rdy_hold_n, 1'b0, "R7 button up");
        step_sw = 1'b1;
        cyc(DEB + 4);
        chk(rdy_hold_n, 1'b1, "R7 second press");
        sync_pulse();
        chk(rdy_hold_n, 1'b0, "R7 second rehold");
        step_sw = 1'b0;
        settle();

        // R9: short bounce is filtered
        step_sw = 1'b1;
        cyc(3);
        step_sw = 1'b0;
        cyc(3 * DEB);
        chk(rdy_hold_n, 1'b0, "R9 bounce ignored");

        // R8: clear enable resumes
        bp_en_sw = 1'b0;
        cyc(DEB + 4);
        chk(rdy_hold_n, 1'b1, "R8 resume");

        // R5: stop anywhere
        bus_addr = AW'($urandom);
        stop_sw  = 1'b1;
        cyc(DEB + 4);
        chk(rdy_hold_n, 1'b0, "R5 stop holds");
        stop_sw = 1'b0;
        cyc(DEB + 4);
        chk(rdy_hold_n, 1'b1, "R8 resume after stop");

        // R10: reset while held
        stop_sw = 1'b1;
        settle();
        chk(rdy_hold_n, 1'b0, "R10 held before reset");
        stop_sw = 1'b0;
        #3 rst_n = 1'b0;
        #2;
        chk(rdy_hold_n, 1'b1, "R10 reset releases");
        cyc(2);
        rst_n = 1'b1;
        cyc(3);
        chk(rdy_hold_n, 1'b1, "R10 after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule